// File: doc/BRIEF.md
# Audio Stream Descriptor Control Unit

This block is the control and status front end of one DMA stream in a serial audio link controller. Software writes a 24-bit control word. The word holds a 4-bit stream tag, three interrupt enables, a run request and a stream-reset bit. A 5-bit status word gathers hardware events: a completed buffer whose descriptor asked for notification, a FIFO overrun or underrun, and a descriptor error. Software clears each status bit by writing 1 to it. The interrupt line is raised by any status bit whose enable is set.

The run bit is read back through a handshake with the DMA engine. After software drops the request, the bit keeps reading 1 until the engine reports that it has really stopped. While the run bit reads 1, the stream tag is locked.

A parameter selects the stream direction:
- An input stream compares the tag of each incoming sample block with its own tag and tells the link receiver whether to accept the block.
- An output stream sends a one-cycle reset to its cadence generator each time the run request goes from 0 to 1.

Top module: `stream_desc_ctl`

## Requirements
- R1: After reset the control word reads 0x040000, the status word reads 0, and irq, dmaEnable and cadenceRst are 0.
- R2: Control bit 18 always reads 1. Bits 19, 17:16 and 15:5 always read 0, and writes to them are ignored.
- R3: Control bits 23:20 hold the stream tag. On an input stream, rxAccept is 1 exactly when rxValid is 1, rxTag equals the stored tag, and the stored tag is not 0 (tag value 0 is reserved).
- R4: Status bit 2 is set by cmplEvt, status bit 3 by fifoErrEvt and status bit 4 by descErrEvt, one cycle after the event and whatever the enable bits are. Status bits 1:0 always read 0.
- R5: irq is 1 exactly when some status bit k in {2,3,4} is set while control bit k (its enable) is 1.
- R6: Writing 1 to a status bit through stsWrEn clears it. If an event for the same bit arrives in the same cycle, the event wins and the bit stays set.
- R7: Control bit 1 is the run request. dmaEnable is 1 exactly when the stored run request is 1 and syncHold is 0.
- R8: Control bit 1 reads 1 whenever the stored run request is 1 or dmaStopped is 0. After a write of 0 to the run request, it keeps reading 1 until dmaStopped is 1.
- R9: On an output stream, cadenceRst is high for exactly one cycle, in the cycle after a write that takes the run request from 0 to 1. An input stream never raises cadenceRst, and an output stream never raises rxAccept.
- R10: A control write made while bit 1 reads 1 leaves the tag unchanged. The other writable fields of that write, including a run request of 0, still take effect.
- R11: While control bit 0 (stream reset) is 1, every status bit is held at 0, even when events arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 24 | Control word write data |
| ctlRdData | output | 24 | Control word read value |
| stsWrEn | input | 1 | Status write-1-to-clear strobe |
| stsWrData | input | 5 | Status clear mask |
| stsRdData | output | 5 | Status word read value |
| cmplEvt | input | 1 | Buffer with completion flag finished |
| fifoErrEvt | input | 1 | FIFO overrun (input) or underrun (output) |
| descErrEvt | input | 1 | Descriptor error |
| irq | output | 1 | Stream interrupt |
| dmaStopped | input | 1 | DMA engine reports it is idle |
| syncHold | input | 1 | Stream-sync hold, blocks transfer |
| dmaEnable | output | 1 | Enable to the DMA engine |
| cadenceRst | output | 1 | One-cycle cadence generator reset (output stream) |
| rxValid | input | 1 | Incoming sample block present |
| rxTag | input | 4 | Tag of the incoming block |
| rxAccept | output | 1 | Block belongs to this stream's FIFO |

## Verification
The assertions check on every cycle that the priority bit reads 1, that the run bit reads 1 while the engine is busy, that the tag stays put while the run bit reads 1, that the stream reset clears status, that an event sets its status bit, and that the cadence pulse lasts a single cycle. Other behaviour needs the bench's scenarios and its cycle-by-cycle reference model. These cover event-wins-over-clear collisions, tag matching against the reserved value, the interaction between syncHold and the enable, a run of 0 accepted in a write whose tag is blocked, and the differences between the input and output variants.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CTL_W    = 24;
  localparam int STS_W    = 5;
  localparam int TAG_W    = 4;
  localparam int TAG_LSB  = 20;
  localparam int PRIO_BIT = 18;
  localparam int SRST_BIT = 0;
  localparam int RUN_BIT  = 1;
  localparam int EVT_LSB  = 2;
  localparam int EVT_N    = 3;

  typedef struct packed {
    logic tagLoad;
    logic cfgLoad;
    logic runRd;
  } ctlStrobe_t;
endpackage

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter bit IS_OUTPUT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrRun,
  input  logic       dmaStopped,
  input  logic       syncHold,
  output ctlStrobe_t strb,
  output logic       dmaEnable,
  output logic       cadenceRst
);
  logic runReq;
  logic runPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReq  <= 1'b0;
      runPrev <= 1'b0;
    end else begin
      runPrev <= runReq;
      if (wrEn) runReq <= wrRun;
    end
  end

  always_comb begin
    strb.runRd   = runReq | ~dmaStopped;
    strb.cfgLoad = wrEn;
    strb.tagLoad = wrEn & ~strb.runRd;
  end

  assign dmaEnable = runReq & ~syncHold;

  generate
    if (IS_OUTPUT) begin : gOutCad
      assign cadenceRst = runReq & ~runPrev;
    end else begin : gInCad
      assign cadenceRst = 1'b0;
    end
  endgenerate

  // R9: the cadence reset never lasts two cycles
  a_r9_cadence_single: assert property (@(posedge clk) disable iff (!rstN)
    cadenceRst |=> !cadenceRst);

  // R7: the enable never rises while the sync hold is asserted
  a_r7_enable_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaEnable) |-> !syncHold);
endmodule

// File: rtl/sdc_datapath.sv
module sdc_datapath
  import sdc_pkg::*;
#(
  parameter bit IS_OUTPUT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic [CTL_W-1:0] wrData,
  input  logic             stsWrEn,
  input  logic [STS_W-1:0] stsWrData,
  input  logic             cmplEvt,
  input  logic             fifoErrEvt,
  input  logic             descErrEvt,
  input  logic             dmaStopped,
  input  logic             rxValid,
  input  logic [TAG_W-1:0] rxTag,
  output logic [CTL_W-1:0] ctlRdData,
  output logic [STS_W-1:0] stsRdData,
  output logic             irq,
  output logic             rxAccept
);
  logic [TAG_W-1:0] tagQ;
  logic [EVT_N-1:0] enQ;
  logic             srstQ;
  logic [EVT_N-1:0] stsQ;
  logic [EVT_N-1:0] evtIn;
  logic [EVT_N-1:0] clrMask;
  logic             unusedRoBits;

  assign evtIn   = {descErrEvt, fifoErrEvt, cmplEvt};
  assign clrMask = stsWrEn ? stsWrData[EVT_LSB +: EVT_N] : '0;
  assign unusedRoBits = ^{wrData[TAG_LSB-1:EVT_LSB+EVT_N], wrData[RUN_BIT],
                          stsWrData[EVT_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ  <= '0;
      enQ   <= '0;
      srstQ <= 1'b0;
    end else begin
      if (strb.tagLoad) tagQ <= wrData[TAG_LSB +: TAG_W];
      if (strb.cfgLoad) begin
        enQ   <= wrData[EVT_LSB +: EVT_N];
        srstQ <= wrData[SRST_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      stsQ <= '0;
    else if (srstQ) stsQ <= '0;
    else            stsQ <= (stsQ & ~clrMask) | evtIn;
  end

  always_comb begin
    ctlRdData = '0;
    ctlRdData[TAG_LSB +: TAG_W] = tagQ;
    ctlRdData[PRIO_BIT]         = 1'b1;
    ctlRdData[EVT_LSB +: EVT_N] = enQ;
    ctlRdData[RUN_BIT]          = strb.runRd;
    ctlRdData[SRST_BIT]         = srstQ;
    stsRdData = '0;
    stsRdData[EVT_LSB +: EVT_N] = stsQ;
  end

  assign irq = |(stsQ & enQ);

  generate
    if (IS_OUTPUT) begin : gOutRx
      assign rxAccept = 1'b0;
    end else begin : gInRx
      assign rxAccept = rxValid && (tagQ != '0) && (rxTag == tagQ);
    end
  endgenerate

  // R2: priority bit is always set
  a_r2_prio_set: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[PRIO_BIT]);

  // R8: run reads 1 while the engine is busy
  a_r8_run_busy: assert property (@(posedge clk) disable iff (!rstN)
    !dmaStopped |-> ctlRdData[RUN_BIT]);

  // R10: tag locked after a cycle in which run read 1
  a_r10_tag_locked: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlRdData[RUN_BIT]) |-> $stable(ctlRdData[TAG_LSB +: TAG_W]));

  // R11: stream reset clears the status word
  a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[SRST_BIT] |=> stsRdData == '0);

  // R4: a completion event sets its bit unless the stream is held in reset
  a_r4_cmpl_sets: assert property (@(posedge clk) disable iff (!rstN)
    (cmplEvt && !ctlRdData[SRST_BIT]) |=> stsRdData[EVT_LSB]);
endmodule

// File: rtl/stream_desc_ctl.sv
module stream_desc_ctl
  import sdc_pkg::*;
#(
  parameter bit IS_OUTPUT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CTL_W-1:0] wrData,
  output logic [CTL_W-1:0] ctlRdData,
  input  logic             stsWrEn,
  input  logic [STS_W-1:0] stsWrData,
  output logic [STS_W-1:0] stsRdData,
  input  logic             cmplEvt,
  input  logic             fifoErrEvt,
  input  logic             descErrEvt,
  output logic             irq,
  input  logic             dmaStopped,
  input  logic             syncHold,
  output logic             dmaEnable,
  output logic             cadenceRst,
  input  logic             rxValid,
  input  logic [TAG_W-1:0] rxTag,
  output logic             rxAccept
);
  ctlStrobe_t strb;

  sdc_ctrl #(.IS_OUTPUT(IS_OUTPUT)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrRun      (wrData[RUN_BIT]),
    .dmaStopped (dmaStopped),
    .syncHold   (syncHold),
    .strb       (strb),
    .dmaEnable  (dmaEnable),
    .cadenceRst (cadenceRst)
  );

  sdc_datapath #(.IS_OUTPUT(IS_OUTPUT)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .stsWrEn    (stsWrEn),
    .stsWrData  (stsWrData),
    .cmplEvt    (cmplEvt),
    .fifoErrEvt (fifoErrEvt),
    .descErrEvt (descErrEvt),
    .dmaStopped (dmaStopped),
    .rxValid    (rxValid),
    .rxTag      (rxTag),
    .ctlRdData  (ctlRdData),
    .stsRdData  (stsRdData),
    .irq        (irq),
    .rxAccept   (rxAccept)
  );
endmodule

// File: tb/stream_desc_ctl_test.sv
`timescale 1ns/1ps
module stream_desc_ctl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [23:0] wrData = '0;
  logic stsWrEn = 1'b0;
  logic [4:0] stsWrData = '0;
  logic cmplEvt = 1'b0, fifoErrEvt = 1'b0, descErrEvt = 1'b0;
  logic dmaStopped = 1'b1, syncHold = 1'b0;
  logic rxValid = 1'b0;
  logic [3:0] rxTag = '0;

  logic [23:0] ctlI, ctlO;
  logic [4:0]  stsI, stsO;
  logic irqI, irqO, enI, enO, cadI, cadO, accI, accO;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  stream_desc_ctl #(.IS_OUTPUT(1'b0)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .ctlRdData(ctlI),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .stsRdData(stsI),
    .cmplEvt(cmplEvt), .fifoErrEvt(fifoErrEvt), .descErrEvt(descErrEvt),
    .irq(irqI), .dmaStopped(dmaStopped), .syncHold(syncHold),
    .dmaEnable(enI), .cadenceRst(cadI), .rxValid(rxValid), .rxTag(rxTag),
    .rxAccept(accI));

  stream_desc_ctl #(.IS_OUTPUT(1'b1)) uutOut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .ctlRdData(ctlO),
    .stsWrEn(stsWrEn), .stsWrData(stsWrData), .stsRdData(stsO),
    .cmplEvt(cmplEvt), .fifoErrEvt(fifoErrEvt), .descErrEvt(descErrEvt),
    .irq(irqO), .dmaStopped(dmaStopped), .syncHold(syncHold),
    .dmaEnable(enO), .cadenceRst(cadO), .rxValid(rxValid), .rxTag(rxTag),
    .rxAccept(accO));

  // behavioural reference model
  int mTag, mEn, mRun, mSrst, mSts, mPrev;
  always @(posedge clk) begin
    int busy, nSts;
    if (!rstN) begin
      mTag = 0; mEn = 0; mRun = 0; mSrst = 0; mSts = 0; mPrev = 0;
    end else begin
      busy = (mRun != 0 || !dmaStopped) ? 1 : 0;
      nSts = mSts;
      if (stsWrEn) nSts = nSts & ~(stsWrData & 5'h1C);
      if (cmplEvt) nSts = nSts | 4;
      if (fifoErrEvt) nSts = nSts | 8;
      if (descErrEvt) nSts = nSts | 16;
      if (mSrst != 0) nSts = 0;
      mPrev = mRun;
      if (wrEn) begin
        if (busy == 0) mTag = int'(wrData[23:20]);
        mEn = int'(wrData[4:2]);
        mRun = int'(wrData[1]);
        mSrst = int'(wrData[0]);
      end
      mSts = nSts;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    int expCtl, expIrq, expAcc;
    if (rstN) begin
      expCtl = (mTag << 20) | 32'h40000 | (mEn << 2) |
               (((mRun != 0) || !dmaStopped) ? 2 : 0) | mSrst;
      expIrq = ((mSts >> 2) & mEn) != 0 ? 1 : 0;
      expAcc = (rxValid && mTag != 0 && int'(rxTag) == mTag) ? 1 : 0;
      check("R1/R2/R3/R8/R10 ctl in", int'(ctlI), expCtl);
      check("R1/R2/R3/R8/R10 ctl out", int'(ctlO), expCtl);
      check("R4/R6/R11 sts", int'(stsI), mSts);
      check("R4/R6/R11 sts out", int'(stsO), mSts);
      check("R5 irq", int'(irqI), expIrq);
      check("R7 dmaEnable", int'(enI), (mRun != 0 && !syncHold) ? 1 : 0);
      check("R9 cadence out", int'(cadO), (mRun != 0 && mPrev == 0) ? 1 : 0);
      check("R9 cadence in", int'(cadI), 0);
      check("R3 rxAccept", int'(accI), expAcc);
      check("R9 rxAccept out", int'(accO), 0);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [23:0] v);
    wrEn = 1'b1; wrData = v; cyc(); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic clr(logic [4:0] m);
    stsWrEn = 1'b1; stsWrData = m; cyc(); stsWrEn = 1'b0; stsWrData = '0;
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc();
    check("R1 reset ctl", int'(ctlI), 32'h040000);
    check("R1 reset sts", int'(stsI), 0);
    check("R1 reset irq", int'(irqI), 0);

    // R2: all-ones write except run; read-only bits keep their values
    wr(24'hFFFFFD);
    check("R2 ro bits", int'(ctlI), 32'hF4001D);
    // R11: events while stream reset is set are discarded
    cmplEvt = 1; fifoErrEvt = 1; descErrEvt = 1; cyc();
    cmplEvt = 0; fifoErrEvt = 0; descErrEvt = 0; cyc();
    check("R11 srst holds", int'(stsI), 0);

    // R4/R5: events with enables off set status but no irq
    wr(24'h300000);
    fifoErrEvt = 1; cyc(); fifoErrEvt = 0;
    check("R4 fifo err bit3", int'(stsI), 32'h08);
    check("R5 irq disabled", int'(irqI), 0);
    wr(24'h300008);
    check("R5 irq enabled", int'(irqI), 1);
    // R6: event beats clear in same cycle
    stsWrEn = 1; stsWrData = 5'h08; fifoErrEvt = 1; cyc();
    stsWrEn = 0; stsWrData = 0; fifoErrEvt = 0;
    check("R6 event wins", int'(stsI), 32'h08);
    clr(5'h1F);
    check("R6 w1c clears", int'(stsI), 0);
    check("R6 irq drops", int'(irqI), 0);
    cmplEvt = 1; descErrEvt = 1; cyc(); cmplEvt = 0; descErrEvt = 0;
    check("R4 cmpl+desc bits", int'(stsI), 32'h14);
    clr(5'h04);
    check("R6 partial clear", int'(stsI), 32'h10);
    clr(5'h10);

    // R3: tag matching
    rxValid = 1; rxTag = 4'h3; #1;
    check("R3 tag match", int'(accI), 1);
    rxTag = 4'h4; #1;
    check("R3 tag mismatch", int'(accI), 0);
    rxValid = 0; cyc();
    wr(24'h000000);
    rxValid = 1; rxTag = 4'h0; #1;
    check("R3 reserved tag", int'(accI), 0);
    rxValid = 0;

    // R7/R9: run with sync hold
    syncHold = 1;
    wr(24'h500002);
    check("R9 cadence pulse", int'(cadO), 1);
    check("R7 held by sync", int'(enI), 0);
    cyc();
    check("R9 cadence single", int'(cadO), 0);
    syncHold = 0; #1;
    check("R7 enabled", int'(enI), 1);
    dmaStopped = 0; cyc(2);

    // R10: tag write blocked while running, run=0 accepted
    wr(24'hA00000);
    check("R10 tag kept", int'(ctlI[23:20]), 5);
    check("R8 run still reads 1", int'(ctlI[1]), 1);
    check("R7 enable off", int'(enI), 0);
    cyc(3);
    dmaStopped = 1; #1;
    check("R8 run reads 0", int'(ctlI[1]), 0);
    wr(24'hA00000);
    check("R10 tag written idle", int'(ctlI[23:20]), 10);
    rxValid = 1; rxTag = 4'hA; cyc(2); rxValid = 0;

    // back-to-back run toggles for the cadence generator
    wr(24'h000002); wr(24'h000000); wr(24'h000002); cyc(2);
    wr(24'h000000); cyc(2);

    // random-ish mix compared by the model
    for (int i = 0; i < 400; i++) begin
      int r = (i * 37 + 11) % 97;
      wrEn = (r % 7 == 0); wrData = 24'(r * 123457);
      stsWrEn = (r % 5 == 0); stsWrData = 5'(r);
      cmplEvt = (r % 3 == 0); fifoErrEvt = (r % 4 == 1); descErrEvt = (r % 11 == 2);
      dmaStopped = (r % 6 != 0); syncHold = (r % 9 == 0);
      rxValid = r[0]; rxTag = 4'(r);
      cyc();
    end
    wrEn = 0; stsWrEn = 0; cmplEvt = 0; fifoErrEvt = 0; descErrEvt = 0;
    dmaStopped = 1; syncHold = 0; rxValid = 0;
    cyc(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule